// File: doc/BRIEF.md
# Binary Kernel Convolver with Result Reuse

This block evaluates 3x3 binary convolution results for a set of parallel lanes. Each lane takes a 9-bit input window and a 9-bit weight word and yields a small signed count. An ordinary kernel's count is the number of window positions whose input bit matches the weight bit. The block avoids recounting a kernel that is closely related to one it has just counted. Each lane keeps the count of the last reference kernel it processed. A later derived kernel on that lane sets the same weights plus one more position, and sees the same window. Its count is taken from the stored reference count and adjusted by the input bit at the added position.

Each lane carries a 2-bit operation tag. The tag selects an independent count, a reference count (counted and then kept), or a derived count (taken from the kept value). A derived operation also carries the index of the added position. Which kernels are related is worked out before run time, and the tags arrive with each operation as configuration. All lanes share one input strobe and one output strobe. Each result is registered and appears one clock after its operation is accepted.

Top module: `bin_kernel_conv`

## Requirements
- R1: While reset is held and until the first accepted operation afterwards, `valid_o` is 0 and every lane result is 0. Each lane's stored reference count also starts at 0.
- R2: For tag 2'b00 (independent) or 2'b11 (treated as independent), the lane result one cycle after acceptance equals the number of positions i in 0..8 where window bit i equals weight bit i. Lane L uses window and weight bits [L*9 +: 9], and position i is row*3+column.
- R3: For tag 2'b01 (reference), the lane result is computed as in R2, and the same value is stored as that lane's reference count.
- R4: For tag 2'b10 (derived), the lane result equals stored reference count + 2*window[a] - 1, where a is the lane's 4-bit position field `pos_i[L*4 +: 4]`. A reference accepted in one cycle can be used by a derived operation in the very next cycle. The result equals the direct count of R2 for the derived kernel's weights whenever the relation holds.
- R5: A derived operation ignores its lane's weight bits. Different weight words give the same result.
- R6: Independent and derived operations leave the lane's stored reference count unchanged.
- R7: Results are 5-bit two's complement. A derived operation on a stored count of 0 with window[a]=0 gives -1 (5'b11111).
- R8: A derived position field of 9 to 15 takes the selected input bit as 0, so the result is the stored count minus 1.
- R9: Each lane has its own stored reference count. A reference in one lane does not change the derived result of another lane.
- R10: `valid_o` equals `in_valid` from one cycle earlier. When `in_valid` is 0, results hold their values and no reference count is stored, whatever the tags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept one operation on every lane this cycle |
| window_i | input | LANES*9 | Input windows, 9 bits per lane |
| weight_i | input | LANES*9 | Kernel weights, 9 bits per lane |
| mode_i | input | LANES*2 | Operation tag per lane: 00 independent, 01 reference, 10 derived, 11 independent |
| pos_i | input | LANES*4 | Added-position index per lane for derived operations |
| valid_o | output | 1 | Results below are new this cycle |
| res_o | output | LANES*5 | Signed lane results, 5 bits per lane |

## Verification
The only hidden state is the stored reference count in each lane. If it is wrong, the error shows at the ports on the first derived operation on that lane after the fault, one cycle after that operation is accepted. The result is then off by exactly the error in the stored count. So the stimulus pairs every stored-count hazard with a derived operation right after it: an independent operation, an alternate tag, a dropped strobe, or a reference in a neighbouring lane. Every derived result is also compared with a direct count over the derived kernel's own weights, so a wrong correction sign or a wrong bit select cannot stay hidden.

// File: rtl/bkc_pkg.sv
package bkc_pkg;

  typedef enum logic [1:0] {
    MODE_IND = 2'b00,
    MODE_REF = 2'b01,
    MODE_DER = 2'b10,
    MODE_ALT = 2'b11
  } mode_e;

endpackage

// File: rtl/bkc_xnor_pop.sv
module bkc_xnor_pop #(
  parameter int KBITS = 9,
  parameter int CNT_W = $clog2(KBITS + 1)
) (
  input  logic [KBITS-1:0] win,
  input  logic [KBITS-1:0] wt,
  output logic [CNT_W-1:0] cnt
);

  logic [KBITS-1:0] match;

  always_comb begin
    match = ~(win ^ wt);
    cnt   = '0;
    for (int i = 0; i < KBITS; i++) begin
      cnt = cnt + {{(CNT_W-1){1'b0}}, match[i]};
    end
  end

endmodule

// File: rtl/bkc_correct.sv
module bkc_correct #(
  parameter int KBITS = 9,
  parameter int POS_W = $clog2(KBITS),
  parameter int RES_W = $clog2(KBITS + 1) + 1
) (
  input  logic signed [RES_W-1:0] ref_val,
  input  logic        [KBITS-1:0] win,
  input  logic        [POS_W-1:0] pos,
  output logic signed [RES_W-1:0] der_val
);

  localparam logic signed [RES_W-1:0] ONE_S = RES_W'(1);

  logic                    sel_bit;
  logic signed [RES_W-1:0] bit_s;

  always_comb begin
    sel_bit = (int'(pos) < KBITS) ? win[pos] : 1'b0;
    bit_s   = {{(RES_W-1){1'b0}}, sel_bit};
    der_val = ref_val + bit_s + bit_s - ONE_S;
  end

endmodule

// File: rtl/bkc_lane.sv
module bkc_lane
  import bkc_pkg::*;
#(
  parameter int KBITS = 9,
  parameter int POS_W = $clog2(KBITS),
  parameter int CNT_W = $clog2(KBITS + 1),
  parameter int RES_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  mode_e                   mode,
  input  logic        [KBITS-1:0] win,
  input  logic        [KBITS-1:0] wt,
  input  logic        [POS_W-1:0] pos,
  output logic signed [RES_W-1:0] res_q
);

  localparam logic signed [RES_W-1:0] ONE_S = RES_W'(1);

  logic        [CNT_W-1:0] cnt;
  logic signed [RES_W-1:0] pop_s;
  logic signed [RES_W-1:0] der_val;
  logic signed [RES_W-1:0] ref_q;
  logic signed [RES_W-1:0] res_d;
  logic                    res_en;
  logic                    ref_en;

  bkc_xnor_pop #(.KBITS(KBITS), .CNT_W(CNT_W)) u_pop (
    .win (win),
    .wt  (wt),
    .cnt (cnt)
  );

  bkc_correct #(.KBITS(KBITS), .POS_W(POS_W), .RES_W(RES_W)) u_corr (
    .ref_val (ref_q),
    .win     (win),
    .pos     (pos),
    .der_val (der_val)
  );

  always_comb begin
    pop_s  = {1'b0, cnt};
    res_en = en;
    ref_en = en && (mode == MODE_REF);
    case (mode)
      MODE_DER: res_d = der_val;
      default:  res_d = pop_s;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ref_q <= '0;
    end else begin
      if (res_en) res_q <= res_d;
      if (ref_en) ref_q <= res_d;
    end
  end

  // R6: stored count only moves on an accepted reference
  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && mode == MODE_REF) |=> $stable(ref_q));

  // R3: a reference count is both reported and kept
  assert_ref_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_REF) |=> (ref_q == res_q));

  // R4: a derived result sits one step from the kept count
  assert_derived_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_DER) |=>
      ((res_q == $past(ref_q) + ONE_S) || (res_q == $past(ref_q) - ONE_S)));

  // R2: counted results lie in 0..KBITS
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode != MODE_DER) |=> (res_q >= 0 && res_q <= KBITS));

endmodule

// File: rtl/bin_kernel_conv.sv
module bin_kernel_conv
  import bkc_pkg::*;
#(
  parameter int LANES = 4,
  parameter int KSIZE = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  input  logic [LANES*KSIZE*KSIZE-1:0]              window_i,
  input  logic [LANES*KSIZE*KSIZE-1:0]              weight_i,
  input  logic [LANES*2-1:0]                        mode_i,
  input  logic [LANES*$clog2(KSIZE*KSIZE)-1:0]      pos_i,
  output logic                                      valid_o,
  output logic [LANES*($clog2(KSIZE*KSIZE+1)+1)-1:0] res_o
);

  localparam int KBITS = KSIZE * KSIZE;
  localparam int POS_W = $clog2(KBITS);
  localparam int CNT_W = $clog2(KBITS + 1);
  localparam int RES_W = CNT_W + 1;

  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_s = rst_sync_q[1];

  always_comb valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) valid_o <= 1'b0;
    else        valid_o <= valid_d;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [RES_W-1:0] lane_res;

    bkc_lane #(
      .KBITS (KBITS),
      .POS_W (POS_W),
      .CNT_W (CNT_W),
      .RES_W (RES_W)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_s),
      .en    (in_valid),
      .mode  (mode_e'(mode_i[l*2 +: 2])),
      .win   (window_i[l*KBITS +: KBITS]),
      .wt    (weight_i[l*KBITS +: KBITS]),
      .pos   (pos_i[l*POS_W +: POS_W]),
      .res_q (lane_res)
    );

    assign res_o[l*RES_W +: RES_W] = lane_res;
  end

  // R10: idle cycles leave all results untouched
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |=> $stable(res_o));

endmodule

// File: tb/test_bin_kernel_conv.sv
module test_bin_kernel_conv;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int KB = 9;
  localparam int PW = 4;
  localparam int RW = 5;

  typedef struct packed {
    logic [1:0]        mode;
    logic [3:0]        pos;
    logic [8:0]        win;
    logic [8:0]        wt;
    logic signed [4:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 4'd0, 9'b000000101, 9'b000000011, 5'sd7},
    '{2'b10, 4'd2, 9'b000000101, 9'b000000111, 5'sd8},
    '{2'b10, 4'd3, 9'b000000101, 9'b000001011, 5'sd6},
    '{2'b00, 4'd0, 9'b110100110, 9'b111111111, 5'sd5},
    '{2'b10, 4'd2, 9'b000000101, 9'b000000111, 5'sd8},
    '{2'b01, 4'd0, 9'b100000000, 9'b001111000, 5'sd4},
    '{2'b10, 4'd8, 9'b100000000, 9'b101111000, 5'sd5},
    '{2'b01, 4'd0, 9'b111111100, 9'b000000011, 5'sd0},
    '{2'b10, 4'd2, 9'b111111100, 9'b000000111, 5'sd1}
  };

  logic                  clk;
  logic                  rst_n;
  logic                  in_valid;
  logic [LANES*KB-1:0]   window_i;
  logic [LANES*KB-1:0]   weight_i;
  logic [LANES*2-1:0]    mode_i;
  logic [LANES*PW-1:0]   pos_i;
  logic                  valid_o;
  logic [LANES*RW-1:0]   res_o;

  int n_chk;
  int n_fail;
  bit done;

  bin_kernel_conv #(.LANES(LANES), .KSIZE(3)) i_bin_kernel_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .window_i (window_i),
    .weight_i (weight_i),
    .mode_i   (mode_i),
    .pos_i    (pos_i),
    .valid_o  (valid_o),
    .res_o    (res_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lane_res(int l);
    logic signed [RW-1:0] t;
    t = res_o[l*RW +: RW];
    return int'(t);
  endfunction

  function automatic int pop_xnor(logic [8:0] a, logic [8:0] b);
    int s = 0;
    for (int i = 0; i < 9; i++) if (a[i] == b[i]) s++;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lane(int l, logic [1:0] m, logic [3:0] p, logic [8:0] w_in, logic [8:0] k);
    mode_i[l*2 +: 2]   = m;
    pos_i[l*PW +: PW]  = p;
    window_i[l*KB +: KB] = w_in;
    weight_i[l*KB +: KB] = k;
  endtask

  task automatic set_all(logic [1:0] m, logic [3:0] p, logic [8:0] w_in, logic [8:0] k);
    for (int l = 0; l < LANES; l++) set_lane(l, m, p, w_in, k);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    window_i = '0;
    weight_i = '0;
    mode_i = '0;
    pos_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 valid in reset", int'(valid_o), 0);
    for (int l = 0; l < LANES; l++) check("R1 result in reset", lane_res(l), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid after release", int'(valid_o), 0);
    for (int l = 0; l < LANES; l++) check("R1 result after release", lane_res(l), 0);

    // R7: derived from the reset count 0 with a zero bit gives -1
    in_valid = 1'b1;
    set_all(2'b10, 4'd0, 9'b000000000, 9'b000000001);
    @(negedge clk);
    check("R10 valid follows strobe", int'(valid_o), 1);
    for (int l = 0; l < LANES; l++) check("R7 minus one", lane_res(l), -1);

    // Table walk: R2 R3 R4 with direct count comparison for derived rows
    for (int v = 0; v < NV; v++) begin
      set_all(VECS[v].mode, VECS[v].pos, VECS[v].win, VECS[v].wt);
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        if (VECS[v].mode == 2'b10) begin
          check("R4 derived table", lane_res(l), int'(VECS[v].exp));
          check("R4 derived vs direct count", lane_res(l), pop_xnor(VECS[v].win, VECS[v].wt));
        end else if (VECS[v].mode == 2'b01) begin
          check("R3 reference table", lane_res(l), int'(VECS[v].exp));
        end else begin
          check("R2 independent table", lane_res(l), int'(VECS[v].exp));
        end
      end
    end
    // stored count is now 0 in every lane

    // R2 alternate tag counts; R6 it must not store
    set_all(2'b11, 4'd0, 9'b000000000, 9'b000000000);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) check("R2 alternate tag count", lane_res(l), 9);
    set_all(2'b10, 4'd0, 9'b000000001, 9'b000000001);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) check("R6 count kept after alt/ind", lane_res(l), 1);

    // R5: weights do not matter for derived
    set_all(2'b10, 4'd0, 9'b000000001, 9'b111111111);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) check("R5 weights all ones", lane_res(l), 1);
    set_all(2'b10, 4'd0, 9'b000000001, 9'b000000000);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) check("R5 weights all zeros", lane_res(l), 1);

    // R8: out-of-range position reads as 0
    set_all(2'b10, 4'd12, 9'b111111111, 9'b000000000);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) check("R8 position 12", lane_res(l), -1);

    // R9: per-lane stored counts
    set_lane(0, 2'b01, 4'd0, 9'b000000000, 9'b000000011);
    for (int l = 1; l < LANES; l++) set_lane(l, 2'b01, 4'd0, 9'b000000011, 9'b000000011);
    @(negedge clk);
    check("R9 lane0 reference", lane_res(0), 7);
    for (int l = 1; l < LANES; l++) check("R9 other lane reference", lane_res(l), 9);
    set_lane(0, 2'b10, 4'd2, 9'b000000000, 9'b000000111);
    for (int l = 1; l < LANES; l++) set_lane(l, 2'b10, 4'd2, 9'b000000011, 9'b000000111);
    @(negedge clk);
    check("R9 lane0 derived", lane_res(0), 6);
    for (int l = 1; l < LANES; l++) check("R9 other lane derived", lane_res(l), 8);

    // R10: idle cycle with a reference tag stores nothing, results hold
    in_valid = 1'b0;
    set_all(2'b01, 4'd0, 9'b111111111, 9'b000000000);
    @(negedge clk);
    check("R10 valid low", int'(valid_o), 0);
    check("R10 lane0 hold", lane_res(0), 6);
    for (int l = 1; l < LANES; l++) check("R10 other lane hold", lane_res(l), 8);
    in_valid = 1'b1;
    set_lane(0, 2'b10, 4'd2, 9'b000000000, 9'b000000000);
    for (int l = 1; l < LANES; l++) set_lane(l, 2'b10, 4'd2, 9'b000000000, 9'b000000000);
    @(negedge clk);
    check("R10 lane0 count not stored when idle", lane_res(0), 6);
    for (int l = 1; l < LANES; l++) check("R10 other lane count not stored", lane_res(l), 8);

    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule